// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides when a processor core takes an exception and how it leaves one. Each cycle it looks at the pending causes: a reset request, an undefined-instruction flag, a software-interrupt flag, instruction-fetch and data-access aborts, and the normal and fast interrupt lines. The interrupt lines are gated by the mask bits of the current status word. When a cause wins, the block saves the old status word and the return address through the write port of the banked register file. In the same cycle it switches the status word to the exception's mode, raises the mask bits, drops the compact-instruction state bit and sends the program counter to the cause's vector slot. A configuration input selects one of two vector bases, low at address zero or high at 0xFFFF0000.

A return request reverses the transfer. The status word is loaded from the saved copy of the current mode and the program counter from that mode's link value, both read from the banked file. A return is refused when the core is in the compact-instruction state, and also when the current mode has no saved copy. All outputs are registered, so every action shows at the ports one clock after the cycle in which it is decided.

Top module: `excp_sequencer`

## Requirements
- R1: After the block reset, the status word reads 0x000000D3: supervisor mode, both interrupt masks set, compact state clear, flags zero. `pc_we` and `bank_we` are low.
- R2: The vector address is the base plus four times the cause code. The base is 0 with `hi_vec`=0 and 0xFFFF0000 with `hi_vec`=1. The cause codes are reset 0, undefined 1, software interrupt 2, fetch abort 3, data abort 4, normal interrupt 6 and fast interrupt 7. Code 5 is never used.
- R3: One cycle after a cause is taken, `pc_we` and `bank_we` are high and `pc_next` holds the vector. `bank_mode` holds the new mode, `bank_spsr` the status word from before the entry, and `bank_lr` the `ret_addr` value presented in the entry cycle.
- R4: The status word holds the mode in bits 4:0, the compact-state bit in bit 5, the fast mask in bit 6, the normal mask in bit 7 and the N, Z, C, V flags in bits 31:28. The mode codes are user 10000, fast 10001, normal 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Reset and software interrupt enter supervisor mode. Both aborts enter abort mode. Each of the other causes enters the mode of its own name. Entry clears bit 5 and keeps bits 31:8.
- R5: Every entry sets bit 7. Reset and fast-interrupt entries also set bit 6. Every other entry leaves bit 6 unchanged.
- R6: When several causes are pending, the winner is chosen in this order: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined, software interrupt.
- R7: `irq_req` has no effect while bit 7 is set. `fiq_req` has no effect while bit 6 is set.
- R8: A return request with no cause pending, bit 5 clear and the mode fast, normal, supervisor, abort or undefined does three things one cycle later. The status word equals `saved_psr`, `pc_next` equals `saved_lr` with `pc_we` high, and `bank_we` stays low.
- R9: A return request is refused when bit 5 is set or the mode is user or system. One cycle later `ret_reject` is high, `pc_we` is low and the status word is unchanged.
- R10: `psr_we` loads `psr_wdata` into the status word only when no cause is taken and no return is accepted in that cycle. An exception entry wins over a return and over a direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| hi_vec | input | 1 | Selects the high vector base |
| rst_req | input | 1 | Reset exception request |
| und_req | input | 1 | Undefined-instruction request |
| swi_req | input | 1 | Software-interrupt request |
| pabt_req | input | 1 | Instruction-fetch abort request |
| dabt_req | input | 1 | Data-access abort request |
| irq_req | input | 1 | Normal interrupt line |
| fiq_req | input | 1 | Fast interrupt line |
| ret_addr | input | ADDR_W | Return address to save on entry |
| ret_req | input | 1 | Exception return request |
| saved_psr | input | 32 | Saved status copy of the current mode |
| saved_lr | input | ADDR_W | Link value of the current mode |
| psr_we | input | 1 | Direct status word write enable |
| psr_wdata | input | 32 | Direct status word write data |
| cpsr | output | 32 | Current status word |
| mode | output | 5 | Current mode field |
| pc_we | output | 1 | Program counter load strobe |
| pc_next | output | ADDR_W | Program counter load value |
| bank_we | output | 1 | Banked register file write strobe |
| bank_mode | output | 5 | Bank selected for the write |
| bank_lr | output | ADDR_W | Link value to write |
| bank_spsr | output | 32 | Saved status value to write |
| ret_reject | output | 1 | Refused return pulse |

## Verification
The bench builds the block with its defaults: a 32-bit address and the high base at 0xFFFF0000. With these values both vector bases can be reached as full addresses, and every cause code can be checked against its exact slot. Entries from user mode are tested with nonzero flags, so the test shows that bits 31:8 are kept and that the mask bits are raised. The priority chain is tested by removing the winning cause one at a time. The masked and unmasked interrupt combinations, the accepted and refused returns, and the cases where an entry competes with a return or a direct write are each driven on purpose.

// File: rtl/excp_pkg.sv
package excp_pkg;

  // Cause codes double as vector slot indices.
  typedef enum logic [2:0] {
    K_RST  = 3'd0,
    K_UND  = 3'd1,
    K_SWI  = 3'd2,
    K_PABT = 3'd3,
    K_DABT = 3'd4,
    K_RSVD = 3'd5,
    K_IRQ  = 3'd6,
    K_FIQ  = 3'd7
  } kind_e;

  localparam int KIND_N = 8;
  localparam int PSR_W  = 32;
  localparam int MODE_W = 5;

  localparam int B_I = 7;
  localparam int B_F = 6;
  localparam int B_T = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  // Rank 0 is served first.
  function automatic kind_e rank_kind(input int r);
    case (r)
      0:       return K_RST;
      1:       return K_DABT;
      2:       return K_FIQ;
      3:       return K_IRQ;
      4:       return K_PABT;
      5:       return K_UND;
      6:       return K_SWI;
      default: return K_RSVD;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] target_mode(input kind_e k);
    case (k)
      K_RST, K_SWI:   return M_SVC;
      K_UND:          return M_UND;
      K_PABT, K_DABT: return M_ABT;
      K_IRQ:          return M_IRQ;
      K_FIQ:          return M_FIQ;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic logic raises_fmask(input kind_e k);
    return (k == K_RST) || (k == K_FIQ);
  endfunction

  function automatic logic has_saved_copy(input logic [MODE_W-1:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [PSR_W-1:0] entry_psr(input logic [PSR_W-1:0] old,
                                                 input kind_e k);
    logic [PSR_W-1:0] p;
    p              = old;
    p[MODE_W-1:0]  = target_mode(k);
    p[B_T]         = 1'b0;
    p[B_I]         = 1'b1;
    if (raises_fmask(k)) p[B_F] = 1'b1;
    return p;
  endfunction

endpackage

// File: rtl/excp_arbiter.sv
module excp_arbiter
  import excp_pkg::*;
#(
  parameter int N = KIND_N
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output kind_e        kind
);

  always_comb begin
    valid = 1'b0;
    kind  = K_RST;
    // Walk from lowest to highest rank so the highest rank wins last.
    for (int r = N - 1; r >= 0; r--) begin
      if (req[rank_kind(r)]) begin
        valid = 1'b1;
        kind  = rank_kind(r);
      end
    end
  end

endmodule

// File: rtl/excp_vector.sv
module excp_vector
  import excp_pkg::*;
#(
  parameter int               ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  kind_e             kind,
  input  logic              hi_vec,
  output logic [ADDR_W-1:0] vec
);

  localparam int PAD_W = ADDR_W - 5;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign base = hi_vec ? HI_BASE : '0;
  assign offs = {{PAD_W{1'b0}}, kind, 2'b00};
  assign vec  = base + offs;

endmodule

// File: rtl/excp_psr_reg.sv
module excp_psr_reg
  import excp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  kind_e            ent_kind,
  input  logic             ret_ok,
  input  logic [PSR_W-1:0] saved_psr,
  input  logic             psr_we,
  input  logic [PSR_W-1:0] psr_wdata,
  output logic [PSR_W-1:0] cpsr
);

  logic [PSR_W-1:0] cpsr_d;

  always_comb begin
    cpsr_d = cpsr;
    if (take)        cpsr_d = entry_psr(cpsr, ent_kind);
    else if (ret_ok) cpsr_d = saved_psr;
    else if (psr_we) cpsr_d = psr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpsr <= PSR_RESET;
    else        cpsr <= cpsr_d;
  end

endmodule

// File: rtl/excp_sequencer.sv
module excp_sequencer
  import excp_pkg::*;
#(
  parameter int               ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_vec,
  input  logic              rst_req,
  input  logic              und_req,
  input  logic              swi_req,
  input  logic              pabt_req,
  input  logic              dabt_req,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              ret_req,
  input  logic [31:0]       saved_psr,
  input  logic [ADDR_W-1:0] saved_lr,
  input  logic              psr_we,
  input  logic [31:0]       psr_wdata,
  output logic [31:0]       cpsr,
  output logic [4:0]        mode,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_next,
  output logic              bank_we,
  output logic [4:0]        bank_mode,
  output logic [ADDR_W-1:0] bank_lr,
  output logic [31:0]       bank_spsr,
  output logic              ret_reject
);

  // Named internal events, used by the bound checker.
  logic              take_evt;
  logic              ret_ok_evt;
  logic              ret_bad_evt;
  kind_e             win_kind;
  logic [KIND_N-1:0] req_vec;
  logic [ADDR_W-1:0] vec_addr;
  logic              irq_live;
  logic              fiq_live;

  assign irq_live = irq_req & ~cpsr[B_I];
  assign fiq_live = fiq_req & ~cpsr[B_F];

  // Bit index equals cause code; the reserved slot never requests.
  assign req_vec = {fiq_live, irq_live, 1'b0, dabt_req,
                    pabt_req, swi_req, und_req, rst_req};

  excp_arbiter #(.N(KIND_N)) arb_i (
    .req   (req_vec),
    .valid (take_evt),
    .kind  (win_kind)
  );

  excp_vector #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE)) vec_i (
    .kind   (win_kind),
    .hi_vec (hi_vec),
    .vec    (vec_addr)
  );

  assign ret_ok_evt  = ret_req & ~take_evt & ~cpsr[B_T] &
                       has_saved_copy(cpsr[MODE_W-1:0]);
  assign ret_bad_evt = ret_req & ~take_evt & ~ret_ok_evt;

  excp_psr_reg psr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_evt),
    .ent_kind  (win_kind),
    .ret_ok    (ret_ok_evt),
    .saved_psr (saved_psr),
    .psr_we    (psr_we),
    .psr_wdata (psr_wdata),
    .cpsr      (cpsr)
  );

  assign mode = cpsr[MODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_we      <= 1'b0;
      pc_next    <= '0;
      bank_we    <= 1'b0;
      bank_mode  <= M_SVC;
      bank_lr    <= '0;
      bank_spsr  <= '0;
      ret_reject <= 1'b0;
    end else begin
      pc_we      <= take_evt | ret_ok_evt;
      bank_we    <= take_evt;
      ret_reject <= ret_bad_evt;
      if (take_evt) begin
        pc_next   <= vec_addr;
        bank_mode <= target_mode(win_kind);
        bank_lr   <= ret_addr;
        bank_spsr <= cpsr;
      end else if (ret_ok_evt) begin
        pc_next   <= saved_lr;
      end
    end
  end

endmodule

// File: rtl/excp_sequencer_chk.sv
module excp_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req,
  input logic              und_req,
  input logic              swi_req,
  input logic              pabt_req,
  input logic              dabt_req,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [31:0]       saved_psr,
  input logic [ADDR_W-1:0] saved_lr,
  input logic [31:0]       cpsr,
  input logic              pc_we,
  input logic [ADDR_W-1:0] pc_next,
  input logic              bank_we,
  input logic [4:0]        bank_mode,
  input logic [31:0]       bank_spsr,
  input logic              ret_reject,
  input logic              take_evt,
  input logic              ret_ok_evt,
  input logic              ret_bad_evt
);

  // R3
  entry_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> bank_we && pc_we && (bank_mode == cpsr[4:0]) && !cpsr[5]);

  // R3
  entry_spsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> bank_spsr == $past(cpsr));

  // R5
  entry_imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> cpsr[7]);

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> pc_next[1:0] == 2'b00);

  // R7
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr[7] && cpsr[6] && !rst_req && !und_req && !swi_req &&
     !pabt_req && !dabt_req) |-> !take_evt);

  // R8
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok_evt |=> pc_we && !bank_we && (pc_next == $past(saved_lr)) &&
                   (cpsr == $past(saved_psr)));

  // R9
  ret_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad_evt |=> ret_reject && !pc_we && (cpsr == $past(cpsr)));

endmodule

bind excp_sequencer excp_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_req     (rst_req),
  .und_req     (und_req),
  .swi_req     (swi_req),
  .pabt_req    (pabt_req),
  .dabt_req    (dabt_req),
  .irq_req     (irq_req),
  .fiq_req     (fiq_req),
  .saved_psr   (saved_psr),
  .saved_lr    (saved_lr),
  .cpsr        (cpsr),
  .pc_we       (pc_we),
  .pc_next     (pc_next),
  .bank_we     (bank_we),
  .bank_mode   (bank_mode),
  .bank_spsr   (bank_spsr),
  .ret_reject  (ret_reject),
  .take_evt    (take_evt),
  .ret_ok_evt  (ret_ok_evt),
  .ret_bad_evt (ret_bad_evt)
);

// File: tb/excp_sequencer_tb_top.sv
`timescale 1ns/1ps
module excp_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hi_vec, rst_req, und_req, swi_req, pabt_req, dabt_req;
  logic        irq_req, fiq_req, ret_req, psr_we;
  logic [31:0] ret_addr, saved_psr, saved_lr, psr_wdata;
  logic [31:0] cpsr, pc_next, bank_lr, bank_spsr;
  logic [4:0]  mode, bank_mode;
  logic        pc_we, bank_we, ret_reject;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  excp_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .hi_vec(hi_vec), .rst_req(rst_req),
    .und_req(und_req), .swi_req(swi_req), .pabt_req(pabt_req),
    .dabt_req(dabt_req), .irq_req(irq_req), .fiq_req(fiq_req),
    .ret_addr(ret_addr), .ret_req(ret_req), .saved_psr(saved_psr),
    .saved_lr(saved_lr), .psr_we(psr_we), .psr_wdata(psr_wdata),
    .cpsr(cpsr), .mode(mode), .pc_we(pc_we), .pc_next(pc_next),
    .bank_we(bank_we), .bank_mode(bank_mode), .bank_lr(bank_lr),
    .bank_spsr(bank_spsr), .ret_reject(ret_reject)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_mode(input int k);
    case (k)
      0, 2:    return 5'b10011;
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      6:       return 5'b10010;
      default: return 5'b10001;
    endcase
  endfunction

  task automatic clear_in();
    rst_req = 0; und_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
    irq_req = 0; fiq_req = 0; ret_req = 0; psr_we = 0;
  endtask

  task automatic set_req(input int k);
    case (k)
      0: rst_req  = 1;
      1: und_req  = 1;
      2: swi_req  = 1;
      3: pabt_req = 1;
      4: dabt_req = 1;
      6: irq_req  = 1;
      7: fiq_req  = 1;
      default: ;
    endcase
  endtask

  // Direct status write; the new value is visible at the next negedge.
  task automatic set_psr(input logic [31:0] v);
    @(negedge clk);
    clear_in();
    psr_we = 1; psr_wdata = v;
    @(negedge clk);
    psr_we = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    clear_in();
    hi_vec = 0; ret_addr = 0; saved_psr = 0; saved_lr = 0; psr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cpsr", cpsr, 32'h0000_00D3);
    chk("R1", "pc_we", {31'd0, pc_we}, 0);
    chk("R1", "bank_we", {31'd0, bank_we}, 0);
  endtask

  task automatic t_entry_each();
    for (int k = 0; k < 8; k++) begin
      logic [31:0] base, exp_psr;
      if (k == 5) continue;
      set_psr(32'h5000_0010);
      hi_vec   = k[0];
      base     = hi_vec ? 32'hFFFF_0000 : 32'h0;
      ret_addr = 32'h0000_1000 + k * 16;
      set_req(k);
      @(negedge clk);
      exp_psr = 32'h5000_0080 | ((k == 0 || k == 7) ? 32'h40 : 32'h0) | exp_mode(k);
      chk("R2", "pc_next", pc_next, base + k * 4);
      chk("R3", "pc_we/bank_we", {30'd0, pc_we, bank_we}, 3);
      chk("R3", "bank_spsr", bank_spsr, 32'h5000_0010);
      chk("R3", "bank_lr", bank_lr, 32'h0000_1000 + k * 16);
      chk("R4", "bank_mode", {27'd0, bank_mode}, {27'd0, exp_mode(k)});
      chk("R5", "cpsr", cpsr, exp_psr);
      clear_in();
    end
    hi_vec = 0;
  endtask

  task automatic t_priority();
    int ord[7] = '{0, 4, 7, 6, 3, 1, 2};
    for (int i = 0; i < 7; i++) begin
      set_psr(32'h0000_0010);
      for (int j = i; j < 7; j++) set_req(ord[j]);
      @(negedge clk);
      chk("R6", "winner vector", pc_next, ord[i] * 4);
      chk("R6", "winner mode", {27'd0, mode}, {27'd0, exp_mode(ord[i])});
      clear_in();
    end
  endtask

  task automatic t_masks();
    set_psr(32'h0000_00D0);
    irq_req = 1; fiq_req = 1;
    @(negedge clk);
    chk("R7", "both masked pc_we", {31'd0, pc_we}, 0);
    chk("R7", "both masked cpsr", cpsr, 32'h0000_00D0);
    clear_in();
    set_psr(32'h0000_0050);
    irq_req = 1; fiq_req = 1;
    @(negedge clk);
    chk("R7", "fast masked -> normal", pc_next, 32'h18);
    chk("R5", "fast mask kept", cpsr, 32'h0000_00D2);
    clear_in();
    set_psr(32'h0000_0090);
    irq_req = 1; fiq_req = 1;
    @(negedge clk);
    chk("R7", "normal masked -> fast", pc_next, 32'h1C);
    clear_in();
  endtask

  task automatic t_return();
    set_psr(32'h0000_0092);
    ret_req = 1; saved_psr = 32'h6000_0030; saved_lr = 32'h0000_1234;
    @(negedge clk);
    chk("R8", "cpsr", cpsr, 32'h6000_0030);
    chk("R8", "pc_next", pc_next, 32'h0000_1234);
    chk("R8", "pc_we/bank_we", {30'd0, pc_we, bank_we}, 2);
    clear_in();
  endtask

  task automatic t_return_bad();
    logic [31:0] cases[3] = '{32'h0000_00B2, 32'h0000_0010, 32'h0000_001F};
    for (int i = 0; i < 3; i++) begin
      set_psr(cases[i]);
      ret_req = 1; saved_psr = 32'hF000_0013; saved_lr = 32'h0000_4444;
      @(negedge clk);
      chk("R9", "reject/pc_we", {30'd0, ret_reject, pc_we}, 2);
      chk("R9", "cpsr kept", cpsr, cases[i]);
      clear_in();
    end
  endtask

  task automatic t_conflict();
    set_psr(32'h0000_0010);
    irq_req = 1; psr_we = 1; psr_wdata = 32'hF000_001F;
    @(negedge clk);
    chk("R10", "entry beats write", cpsr, 32'h0000_0092);
    clear_in();
    ret_req = 1; und_req = 1; saved_psr = 32'h0000_0010;
    ret_addr = 32'h0000_0800;
    @(negedge clk);
    chk("R10", "entry beats return", cpsr, 32'h0000_009B);
    chk("R10", "entry beats return pc", pc_next, 32'h4);
    clear_in();
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_entry_each();
    t_priority();
    t_masks();
    t_return();
    t_return_bad();
    t_conflict();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule